// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block divides a local-oscillator clock by a programmable integer and emits one single-cycle pulse per completed division period. The pulse goes to a phase comparator. A 16-bit divisor word and two mode bits select the division path.

- **Prescaled path.** A divide-by-two stage feeds a pulse-swallow counter.
- **Swallow path.** The pulse-swallow counter is driven directly.
- **Direct path.** A plain 12-bit down-counter is used.

The pulse-swallow counter is built from three parts:

- a 4-bit swallow counter,
- a 12-bit main counter,
- a 16/17 dual-modulus stage that the swallow counter steers.

Everything runs in the divider clock domain. The divide-by-two stage and the modulus stage are clock enables rather than derived clocks.

Divisor and mode are sampled only at the start of each period, so a word written mid-period changes nothing until the next period begins. Out-of-range divisors are clamped to the nearest legal bound. An inhibit input freezes the divider and silences the output. When inhibit is released, the divider reloads and starts a fresh period.

Top module: `nsd_divider`

## Requirements
- R1: While reset is asserted, during the reset synchronisation cycles, and while inhibit is held, `div_pulse_o` is 0.
- R2: With `hiband_i` = 1, pulses repeat every 2·N clock cycles, where N is the whole 16-bit word.
- R3: With `hiband_i` = 0 and `fast_sel_i` = 1, pulses repeat every N clock cycles, where N is the whole 16-bit word.
- R4: With both mode bits 0, pulses repeat every D cycles. D is word bits [15:4] (bit 4 is the LSB), and bits [3:0] have no effect on the period.
- R5: In the two swallow modes, N = 16·M + A, where A is word bits [3:0] (the swallow count) and M is word bits [15:4] (the main count). Any A from 0 to 15 gives the exact N.
- R6: In the two swallow modes, a word below 272 acts as 272.
- R7: In direct mode, a bits [15:4] value below 4 acts as 4.
- R8: A change of the word or the mode bits during a period leaves that period's length unchanged. It takes effect from the next period.
- R9: While `inhibit_i` is 1, no pulse appears. After release, the first pulse appears N_eff+1 cycles after the first clock edge at which inhibit is low. N_eff is the effective period.
- R10: Each pulse is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Divider clock (local-oscillator rate) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| inhibit_i | input | 1 | Stops counting and holds the output low; a restart follows release |
| div_word_i | input | 16 | Divisor word |
| hiband_i | input | 1 | 1 selects the divide-by-two prescaled swallow path |
| fast_sel_i | input | 1 | With hiband_i = 0: 1 selects the swallow path, 0 the direct path |
| div_pulse_o | output | 1 | One-cycle pulse per completed division period |

## Verification
Each of the three paths runs with divisors whose swallow count is 0, mid-range and 15, so a wrong modulus split shows up as an off-by-A period. Direct mode is run with the same upper bits but different low nibbles, which proves the low bits are ignored. Words below each mode's floor show whether clamping acts and on which bound. Mid-period changes of the word and of the mode separate period-boundary sampling from immediate use. An inhibit pulse placed in the middle of a period confirms that the output stays silent and that the restart is clean.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  localparam int NSD_WORD_W  = 16;
  localparam int NSD_SW_W    = 4;
  localparam int NSD_DIR_MIN = 4;

  typedef enum logic [1:0] {
    MODE_DIRECT    = 2'd0,
    MODE_SWALLOW   = 2'd1,
    MODE_PRESCALED = 2'd2
  } nsd_mode_e;
endpackage

// File: rtl/nsd_prescaler.sv
module nsd_prescaler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic restart_i,
  input  logic div2_i,
  output logic ce_o
);
  logic ph_q, ph_d;

  always_comb begin
    if (hold_i || restart_i) ph_d = 1'b0;
    else                     ph_d = ~ph_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  assign ce_o = div2_i ? ph_q : 1'b1;

  // R2
  half_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div2_i && ce_o) |=> !(div2_i && ce_o));
endmodule

// File: rtl/nsd_swallow_core.sv
module nsd_swallow_core #(
  parameter int SW_W   = 4,
  parameter int MAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [SW_W-1:0]   sw_ld_i,
  input  logic [MAIN_W-1:0] mc_ld_i,
  output logic              term_o
);
  localparam int DM_W = SW_W + 1;
  localparam logic [DM_W-1:0] LAST_LO = DM_W'((2**SW_W) - 1);
  localparam logic [DM_W-1:0] LAST_HI = DM_W'(2**SW_W);

  logic [DM_W-1:0]   dm_q, dm_d;
  logic [SW_W-1:0]   sw_q, sw_d;
  logic [MAIN_W-1:0] mc_q, mc_d;
  logic [DM_W-1:0]   dm_last;
  logic              carry;

  assign dm_last = (sw_q != '0) ? LAST_HI : LAST_LO;
  assign carry   = (dm_q == dm_last);
  assign term_o  = carry && (mc_q == MAIN_W'(1));

  always_comb begin
    dm_d = dm_q;
    sw_d = sw_q;
    mc_d = mc_q;
    if (load_i) begin
      dm_d = '0;
      sw_d = sw_ld_i;
      mc_d = mc_ld_i;
    end else if (step_i) begin
      if (carry) begin
        dm_d = '0;
        mc_d = mc_q - MAIN_W'(1);
        if (sw_q != '0) sw_d = sw_q - SW_W'(1);
      end else begin
        dm_d = dm_q + DM_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dm_q <= '0;
      sw_q <= '0;
      mc_q <= '1;
    end else begin
      dm_q <= dm_d;
      sw_q <= sw_d;
      mc_q <= mc_d;
    end
  end

  // R5
  main_above_swallow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_q > MAIN_W'(sw_q));

  // R5
  long_modulus_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dm_q == LAST_HI) |-> (sw_q != '0));
endmodule

// File: rtl/nsd_direct_core.sv
module nsd_direct_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_ld_i,
  output logic             term_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign term_o = (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = cnt_ld_i;
    else if (step_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_d;
  end

  // R4
  count_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0);
endmodule

// File: rtl/nsd_divider.sv
module nsd_divider import nsd_pkg::*; #(
  parameter int WORD_W      = NSD_WORD_W,
  parameter int SW_W        = NSD_SW_W,
  parameter int DIR_MIN     = NSD_DIR_MIN,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inhibit_i,
  input  logic [WORD_W-1:0] div_word_i,
  input  logic              hiband_i,
  input  logic              fast_sel_i,
  output logic              div_pulse_o
);
  localparam int MAIN_W = WORD_W - SW_W;
  localparam int SW_MIN = (2**SW_W) * ((2**SW_W) + 1);
  localparam logic [WORD_W-1:0] SW_MIN_W  = WORD_W'(SW_MIN);
  localparam logic [MAIN_W-1:0] DIR_MIN_W = MAIN_W'(DIR_MIN);

  // reset: asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rsync_q[SYNC_STAGES-1];

  // mode decode and divisor clamping on the live inputs
  nsd_mode_e         mode_in;
  logic [WORD_W-1:0] sw_word;
  logic [MAIN_W-1:0] dir_raw, dir_word;

  always_comb begin
    if (hiband_i)        mode_in = MODE_PRESCALED;
    else if (fast_sel_i) mode_in = MODE_SWALLOW;
    else                 mode_in = MODE_DIRECT;
    sw_word  = (div_word_i < SW_MIN_W) ? SW_MIN_W : div_word_i;
    dir_raw  = div_word_i[WORD_W-1:SW_W];
    dir_word = (dir_raw < DIR_MIN_W) ? DIR_MIN_W : dir_raw;
  end

  // period control
  logic      arm_q, arm_d;
  nsd_mode_e mode_q, mode_d;
  logic      pulse_q, pulse_d;
  logic      run, ce, step, first, fire, reload;
  logic      sw_term, dir_term, term;
  logic      is_direct;

  assign run       = !inhibit_i;
  assign is_direct = (mode_q == MODE_DIRECT);
  assign step      = run && arm_q && ce;
  assign term      = is_direct ? dir_term : sw_term;
  assign fire      = step && term;
  assign first     = run && !arm_q;
  assign reload    = first || fire;

  always_comb begin
    arm_d   = run;
    mode_d  = reload ? mode_in : mode_q;
    pulse_d = fire;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      mode_q  <= MODE_DIRECT;
      pulse_q <= 1'b0;
    end else begin
      arm_q   <= arm_d;
      mode_q  <= mode_d;
      pulse_q <= pulse_d;
    end
  end

  assign div_pulse_o = pulse_q;

  nsd_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .hold_i    (!(run && arm_q)),
    .restart_i (reload),
    .div2_i    (mode_q == MODE_PRESCALED),
    .ce_o      (ce)
  );

  nsd_swallow_core #(.SW_W(SW_W), .MAIN_W(MAIN_W)) u_swl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (reload),
    .step_i  (step && !is_direct),
    .sw_ld_i (sw_word[SW_W-1:0]),
    .mc_ld_i (sw_word[WORD_W-1:SW_W]),
    .term_o  (sw_term)
  );

  nsd_direct_core #(.CNT_W(MAIN_W)) u_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (reload),
    .step_i   (step && is_direct),
    .cnt_ld_i (dir_word),
    .term_o   (dir_term)
  );

  // R10
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_pulse_o |=> !div_pulse_o);

  // R9
  inhibit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    inhibit_i |=> !div_pulse_o);
endmodule

// File: tb/sim_nsd_divider.sv
`timescale 1ns/1ps
module sim_nsd_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        inhibit;
  logic [15:0] div_word;
  logic        hib;
  logic        rng;
  logic        div_pulse;

  always #2.5 clk = ~clk;

  nsd_divider u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .inhibit_i   (inhibit),
    .div_word_i  (div_word),
    .hiband_i    (hib),
    .fast_sel_i  (rng),
    .div_pulse_o (div_pulse)
  );

  int    cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard: driver appends, monitor consumes through rd_ptr
  int    exp_q[$];
  string tag_q[$];
  int    ref_cyc = 0;
  int    ref_gen = 0;
  int    drv_checks = 0, drv_errors = 0;
  int    mon_checks = 0, mon_errors = 0;
  int    rd_ptr = 0;
  int    seen_gen = 0;
  int    prev_cyc = 0;
  logic  last_pulse = 1'b0;

  always @(negedge clk) begin
    int act;
    if (ref_gen != seen_gen) begin
      seen_gen = ref_gen;
      prev_cyc = ref_cyc;
    end
    if (div_pulse) begin
      mon_checks++;
      if (rd_ptr >= exp_q.size()) begin
        mon_errors++;
        $display("FAIL R9: unexpected pulse at cycle %0d actual 1 expected 0", cyc);
      end else begin
        act = cyc - prev_cyc;
        if (act != exp_q[rd_ptr]) begin
          mon_errors++;
          $display("FAIL %s: interval actual %0d expected %0d", tag_q[rd_ptr], act, exp_q[rd_ptr]);
        end
        rd_ptr++;
      end
      prev_cyc = cyc;
      // R10: pulse width of one cycle
      mon_checks++;
      if (last_pulse) begin
        mon_errors++;
        $display("FAIL R10: pulse width actual >1 expected 1 at cycle %0d", cyc);
      end
    end
    last_pulse = div_pulse;
  end

  function automatic int expect_n(input logic [15:0] w, input logic h, input logic r);
    int n;
    if (h || r) begin
      n = (w < 16'd272) ? 272 : int'(w);
      return h ? 2 * n : n;
    end
    n = int'(w >> 4);
    return (n < 4) ? 4 : n;
  endfunction

  task automatic push(input int e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic halt();
    @(posedge clk); #1;
    inhibit = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic go(input logic [15:0] w, input logic h, input logic r);
    div_word = w; hib = h; rng = r;
    ref_cyc = cyc;
    ref_gen++;
    inhibit = 1'b0;
  endtask

  task automatic drain();
    while (rd_ptr < exp_q.size()) @(negedge clk);
  endtask

  task automatic run_case(input logic [15:0] w, input logic h, input logic r,
                          input int np, input string tag);
    int e;
    halt();
    e = expect_n(w, h, r);
    push(e + 1, tag);
    for (int i = 1; i < np; i++) push(e, tag);
    go(w, h, r);
    drain();
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", drv_checks + mon_checks, drv_errors + mon_errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: run actual hung expected done");
    drv_errors++;
    report();
    $finish;
  end

  initial begin
    int seen;
    rst_n = 1'b0; inhibit = 1'b1; div_word = 16'd0; hib = 1'b0; rng = 1'b0;
    repeat (4) @(posedge clk);
    // R1: output low in reset
    @(negedge clk);
    drv_checks++;
    if (div_pulse !== 1'b0) begin
      drv_errors++;
      $display("FAIL R1: pulse in reset actual %b expected 0", div_pulse);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      drv_checks++;
      if (div_pulse !== 1'b0) begin
        drv_errors++;
        $display("FAIL R1: pulse after reset actual %b expected 0", div_pulse);
      end
    end

    // R4: direct mode, low nibble ignored
    run_case(16'h0640, 1'b0, 1'b0, 3, "R4");
    run_case(16'h064F, 1'b0, 1'b0, 3, "R4");
    // R3: swallow path driven directly
    run_case(16'd300, 1'b0, 1'b1, 3, "R3");
    // R5: swallow count 8, 15 and 0
    run_case(16'd1000, 1'b0, 1'b1, 2, "R5");
    run_case(16'h01FF, 1'b0, 1'b1, 2, "R5");
    run_case(16'h0120, 1'b0, 1'b1, 2, "R5");
    // R2: prescaled path, swallow count 13
    run_case(16'd301, 1'b1, 1'b0, 3, "R2");
    // R6: clamp in both swallow modes
    run_case(16'd5, 1'b0, 1'b1, 2, "R6");
    run_case(16'd100, 1'b1, 1'b0, 2, "R6");
    // R7: clamp in direct mode
    run_case(16'h0023, 1'b0, 1'b0, 4, "R7");

    // R8: divisor word changed mid-period
    halt();
    push(301, "R8"); push(300, "R8"); push(500, "R8"); push(500, "R8");
    go(16'd300, 1'b0, 1'b1);
    repeat (311) @(posedge clk);
    #1 div_word = 16'd500;
    drain();

    // R8: mode changed mid-period
    halt();
    push(301, "R8"); push(300, "R8"); push(600, "R8"); push(600, "R8");
    go(16'd300, 1'b0, 1'b1);
    repeat (311) @(posedge clk);
    #1 hib = 1'b1;
    drain();

    // R9: inhibit mid-period, then restart
    halt();
    push(101, "R9"); push(100, "R9");
    go(16'h0640, 1'b0, 1'b0);
    drain();
    repeat (30) @(posedge clk);
    #1 inhibit = 1'b1;
    seen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    drv_checks++;
    if (seen != 0) begin
      drv_errors++;
      $display("FAIL R9: pulses while inhibited actual %0d expected 0", seen);
    end
    @(posedge clk); #1;
    push(101, "R9"); push(100, "R9");
    go(16'h0640, 1'b0, 1'b0);
    drain();
    halt();
    repeat (20) @(posedge clk);

    report();
    $finish;
  end
endmodule